// File: doc/BRIEF.md
# Strobe/Acknowledge Acquisition Handshake

This block runs the control side of a data-acquisition front end. An external digitiser asks for service with a request line. The block answers with a ready level when the storage side can take words. Each word then moves under a four-phase exchange. The source raises its strobe with data valid. The block raises an acknowledge and fires a single-cycle capture pulse for the data path. The source drops its strobe, and the block then drops the acknowledge.

An end-of-event input closes the current event. Ready goes low and stays low until the buffer manager reports, through a synchronous done pulse, that the switch to a fresh buffer is complete. A static strap input can stand in for the external request with a request that is always present.

All three asynchronous inputs pass through a configurable synchroniser chain. An option selects active-low input polarity for negative-logic front ends.

Top module: `daq_strobe_handshake`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ready, ack and capture are all 0.
- R2: With the strap at 0 and no buffer switch pending, a change of the request input appears on ready at the third rising clock edge after the change, and not earlier.
- R3: With the strap at 1, ready rises and stays high whatever the level of the request input.
- R4: While ready is high, a rising strobe makes ack rise at the third rising clock edge after the strobe changes.
- R5: capture is high for exactly one cycle, the cycle in which ack rises, and never at any other time.
- R6: ack stays high for as long as the strobe stays high, and falls at the third rising clock edge after the strobe is removed.
- R7: A strobe that is present while ready is low is not acknowledged. It is acknowledged one edge after ready goes high.
- R8: A rising end-of-event input, including a pulse only 50 ns wide, pulls ready low within three edges. Ready then stays low while a request is present until a buffer-done pulse arrives, and goes high at the second edge after that pulse.
- R9: A buffer-done pulse that arrives when no buffer switch is pending has no effect on ready.
- R10: Every completed strobe exchange produces exactly one capture pulse. This holds across many exchanges with varied strobe hold and gap times and with end-of-event cycles in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 1 | Asynchronous readout request from the source |
| perm_req | input | 1 | Static strap; 1 forces a permanent request |
| strobe_in | input | 1 | Asynchronous write strobe from the source |
| eoe_in | input | 1 | Asynchronous end-of-event input, at least 50 ns wide |
| buf_done | input | 1 | Synchronous one-cycle pulse: buffer change completed |
| ready | output | 1 | Storage can accept data |
| ack | output | 1 | Write acknowledge to the source |
| capture | output | 1 | One-cycle pulse telling the data path to take the word |

## Verification
Each asynchronous input reaches the outputs through two synchroniser flops and one state register. Ready, ack and capture therefore respond at the third rising edge after an input change. A buffer-done pulse, which is already synchronous, reaches ready at its second edge. The bench changes inputs on falling edges and counts falling edges after each stimulus. Its timing tests check the output one falling edge before the result is due, to see that it has not yet changed, and again one falling edge after, to see that it has. Steady-state vectors are checked four cycles after they are applied. The randomised transfer run compares the number of capture pulses with the number of completed exchanges.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
   typedef enum logic [1:0] {
      RDY_IDLE   = 2'd0,
      RDY_OPEN   = 2'd1,
      RDY_SWITCH = 2'd2
   } rdy_state_t;

   typedef enum logic {
      ACK_WAIT = 1'b0,
      ACK_HELD = 1'b1
   } ack_state_t;

   localparam int unsigned SYNC_MIN_STAGES = 2;
   localparam int unsigned N_ASYNC_IN      = 3;
   localparam int unsigned IDX_REQ         = 0;
   localparam int unsigned IDX_STB         = 1;
   localparam int unsigned IDX_EOE         = 2;
endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_ready_ctrl.sv
`timescale 1ns/1ps
module hs_ready_ctrl
   import hs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_eff,
   input  logic eoe_s,
   input  logic buf_done,
   output logic ready
);
   rdy_state_t state, state_nx;
   logic       eoe_q;
   logic       eoe_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eoe_q <= 1'b0;
      else        eoe_q <= eoe_s;
   end

   assign eoe_rise = eoe_s & ~eoe_q;

   always_comb begin
      state_nx = state;
      if (eoe_rise) begin
         state_nx = RDY_SWITCH;
      end else begin
         unique case (state)
            RDY_IDLE:   if (req_eff)  state_nx = RDY_OPEN;
            RDY_OPEN:   if (!req_eff) state_nx = RDY_IDLE;
            RDY_SWITCH: if (buf_done) state_nx = RDY_IDLE;
            default:    state_nx = RDY_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= RDY_IDLE;
      else        state <= state_nx;
   end

   assign ready = (state == RDY_OPEN);
endmodule

// File: rtl/hs_ack_ctrl.sv
`timescale 1ns/1ps
module hs_ack_ctrl
   import hs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stb_s,
   input  logic ready,
   output logic ack,
   output logic capture
);
   ack_state_t state;
   logic       take;

   assign take = (state == ACK_WAIT) && stb_s && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ACK_WAIT;
         capture <= 1'b0;
      end else begin
         capture <= take;
         unique case (state)
            ACK_WAIT: if (take)   state <= ACK_HELD;
            ACK_HELD: if (!stb_s) state <= ACK_WAIT;
            default:  state <= ACK_WAIT;
         endcase
      end
   end

   assign ack = (state == ACK_HELD);
endmodule

// File: rtl/daq_strobe_handshake.sv
`timescale 1ns/1ps
module daq_strobe_handshake
   import hs_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          ACTIVE_LOW_IN = 1'b0,
   parameter int unsigned CLK_PERIOD_NS = 20,
   parameter int unsigned MIN_EOE_NS    = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   input  logic perm_req,
   input  logic strobe_in,
   input  logic eoe_in,
   input  logic buf_done,
   output logic ready,
   output logic ack,
   output logic capture
);
   localparam int unsigned EOE_CYCLES = MIN_EOE_NS / CLK_PERIOD_NS;

   generate
      if (SYNC_STAGES < SYNC_MIN_STAGES) begin : g_bad_sync
         $error("daq_strobe_handshake: SYNC_STAGES must be at least 2");
      end
      if (EOE_CYCLES < 2) begin : g_bad_clk
         $error("daq_strobe_handshake: clock too slow to resolve minimum end-of-event width");
      end
   endgenerate

   logic [N_ASYNC_IN-1:0] raw_in;
   logic [N_ASYNC_IN-1:0] pol_in;
   logic [N_ASYNC_IN-1:0] sync_in;
   logic                  req_eff;

   assign raw_in[IDX_REQ] = req_in;
   assign raw_in[IDX_STB] = strobe_in;
   assign raw_in[IDX_EOE] = eoe_in;

   generate
      if (ACTIVE_LOW_IN) begin : g_pol_low
         assign pol_in = ~raw_in;
      end else begin : g_pol_high
         assign pol_in = raw_in;
      end
   endgenerate

   hs_sync #(
      .WIDTH  (N_ASYNC_IN),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pol_in),
      .q       (sync_in)
   );

   assign req_eff = perm_req | sync_in[IDX_REQ];

   hs_ready_ctrl i_ready (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_eff  (req_eff),
      .eoe_s    (sync_in[IDX_EOE]),
      .buf_done (buf_done),
      .ready    (ready)
   );

   hs_ack_ctrl i_ack (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb_s   (sync_in[IDX_STB]),
      .ready   (ready),
      .ack     (ack),
      .capture (capture)
   );
endmodule

// File: rtl/daq_strobe_handshake_chk.sv
`timescale 1ns/1ps
module daq_strobe_handshake_chk (
   input logic clk,
   input logic rst_n,
   input logic strobe_in,
   input logic ready,
   input logic ack,
   input logic capture
);
   assert_ack_gated_by_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(ready));

   assert_capture_only_on_ack_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> $rose(ack));

   assert_ack_rise_fires_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> capture);

   assert_single_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !capture);

   assert_ack_release_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> !$past(strobe_in));
endmodule

bind daq_strobe_handshake daq_strobe_handshake_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .strobe_in (strobe_in),
   .ready     (ready),
   .ack       (ack),
   .capture   (capture)
);

// File: tb/test_daq_strobe_handshake.sv
`timescale 1ns/1ps
module test_daq_strobe_handshake;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_in = 1'b0, perm_req = 1'b0, strobe_in = 1'b0, eoe_in = 1'b0, buf_done = 1'b0;
   logic ready, ack, capture;
   int   tests = 0, fails = 0, cap_cnt = 0;

   always #10 clk = ~clk;

   daq_strobe_handshake i_daq_strobe_handshake (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .perm_req(perm_req),
      .strobe_in(strobe_in), .eoe_in(eoe_in), .buf_done(buf_done),
      .ready(ready), .ack(ack), .capture(capture)
   );

   always @(posedge clk) if (capture) cap_cnt <= cap_cnt + 1;

   // {perm_req, req_in, expected ready}
   localparam logic [2:0] VEC [7] = '{3'b000, 3'b011, 3'b000, 3'b101, 3'b111, 3'b011, 3'b000};

   task automatic chk(input string rq, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic eoe_pulse(input int width_ns);
      @(negedge clk);
      eoe_in = 1'b1;
      #(width_ns);
      eoe_in = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      buf_done = 1'b1;
      cyc(1);
      buf_done = 1'b0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int base;
      int done_xfers;
      cyc(3);
      chk("R1 ready in reset", ready, 0);
      chk("R1 ack in reset", ack, 0);
      chk("R1 capture in reset", capture, 0);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 ready after reset", ready, 0);

      // table of steady-state vectors (R2, R3)
      foreach (VEC[i]) begin
         perm_req = VEC[i][2];
         req_in   = VEC[i][1];
         cyc(4);
         chk($sformatf("R2/R3 vector %0d ready", i), ready, VEC[i][0]);
      end

      // R2 exact timing
      req_in = 1'b1;
      cyc(2); chk("R2 ready not before third edge", ready, 0);
      cyc(1); chk("R2 ready at third edge", ready, 1);

      // R4/R5/R6 basic exchange
      strobe_in = 1'b1;
      cyc(2); chk("R4 ack not before third edge", ack, 0);
      cyc(1); chk("R4 ack at third edge", ack, 1);
      chk("R5 capture with ack rise", capture, 1);
      cyc(1); chk("R5 capture single cycle", capture, 0);
      cyc(5); chk("R6 ack held while strobe", ack, 1);
      strobe_in = 1'b0;
      cyc(2); chk("R6 ack still high before third edge", ack, 1);
      cyc(1); chk("R6 ack falls at third edge", ack, 0);
      chk("R5 no capture on ack fall", capture, 0);

      // R7 strobe while closed
      req_in = 1'b0;
      cyc(4); chk("R7 ready closed", ready, 0);
      strobe_in = 1'b1;
      cyc(6); chk("R7 no ack while closed", ack, 0);
      req_in = 1'b1;
      cyc(3); chk("R7 ready open", ready, 1);
      chk("R7 ack waits one edge", ack, 0);
      cyc(1); chk("R7 ack after ready", ack, 1);
      chk("R7 capture with late ack", capture, 1);
      strobe_in = 1'b0;
      cyc(4); chk("R6 ack released", ack, 0);

      // R8 minimum-width end of event
      eoe_pulse(55);
      cyc(4); chk("R8 ready closed on end of event", ready, 0);
      cyc(10); chk("R8 ready held closed with request", ready, 0);
      done_pulse();
      chk("R8 ready closed one edge after done", ready, 0);
      cyc(1); chk("R8 ready reopens second edge after done", ready, 1);

      // R9 stray done pulse
      done_pulse();
      chk("R9 stray done ready", ready, 1);
      cyc(3); chk("R9 stray done ready later", ready, 1);

      // R8 with strap, request low
      req_in = 1'b0; perm_req = 1'b1;
      cyc(4); chk("R3 strap keeps ready", ready, 1);
      eoe_pulse(50);
      cyc(5); chk("R8 strap ready closed", ready, 0);
      done_pulse();
      cyc(1); chk("R8 strap ready reopens", ready, 1);

      // R10 randomised exchanges with end-of-event cycles
      base = cap_cnt;
      done_xfers = 0;
      for (int n = 0; n < 40; n++) begin
         if (n % 10 == 9) begin
            eoe_pulse(50 + $urandom_range(0, 40));
            cyc(5);
            chk("R8 ready closed in random run", ready, 0);
            done_pulse();
            cyc(1);
         end
         @(negedge clk);
         strobe_in = 1'b1;
         while (!ack) @(negedge clk);
         cyc($urandom_range(0, 5));
         strobe_in = 1'b0;
         while (ack) @(negedge clk);
         done_xfers++;
         cyc($urandom_range(0, 5));
      end
      cyc(2);
      chk("R10 one capture per exchange", cap_cnt - base, done_xfers);
      chk("R10 ack idle at end", ack, 0);

      finish_run();
   end
endmodule